// File: doc/BRIEF.md
# Delta-Sigma Bitstream Input Unit

This block is the front end of a delta-sigma measurement channel. It receives two raw, asynchronous pins from a modulator, a clock pin and a data pin, and turns them into a one-bit sample with a single-cycle strobe in the system clock domain. A static two-bit mode input picks the capture scheme. Three schemes use the modulator clock: sample on rising edges only, on both edges, or on every second rising edge. The fourth scheme ignores the clock pin and decodes a Manchester-coded data line, learning the bit period from the spacing of the data transitions.

Both pins pass through a multi-flop synchroniser before any edge is detected. A watchdog counts system clocks with no activity, meaning no modulator clock edge in the clocked schemes and no data transition in the Manchester scheme. When the count reaches a programmable limit it sets a sticky failure flag. The downstream decimation filters consume `sample_bit` on every cycle in which `sample_vld` is high.

Top module: `dsin_front`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `sample_vld` and `clk_fail` are 0.
- R2: With mode 0, every rising edge on `mod_clk_pin` produces exactly one one-cycle `sample_vld` pulse that carries the level of `mod_dat_pin` at that edge. The pulse is visible on the third system clock edge after the pin change.
- R3: With mode 1, every edge on `mod_clk_pin`, rising or falling, produces one sample of `mod_dat_pin`.
- R4: With mode 3, only the 2nd, 4th, 6th and later rising edges of `mod_clk_pin` produce a sample. The count starts from the first rising edge after reset or after any change of `mode`.
- R5: With mode 2, the data line is Manchester decoded. A transition accepted as mid-bit yields one sample: 1 for a rising transition, 0 for a falling one. A transition is accepted only when at least three quarters of the learned bit period has passed since the last accepted one. The learned period is the longest spacing seen between transitions, so an alternating 1/0 preamble locks the decoder.
- R6: `clk_fail` is set once `timeout` (nonzero) or more system clocks pass without activity. Activity is a modulator clock edge in modes 0, 1 and 3, and a data transition in mode 2.
- R7: `clk_fail` stays set until `fail_clr` is pulsed. A still-active timeout condition has priority over the clear.
- R8: A `timeout` of 0 disables the failure detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Capture scheme: 0 rise, 1 both edges, 2 Manchester, 3 every second rise |
| timeout | input | TMO_W | System clocks without activity before failure; 0 disables |
| fail_clr | input | 1 | Clears the sticky failure flag |
| mod_clk_pin | input | 1 | Raw modulator clock pin |
| mod_dat_pin | input | 1 | Raw modulator data pin |
| sample_bit | output | 1 | Captured bitstream value |
| sample_vld | output | 1 | One-cycle strobe marking a new `sample_bit` |
| clk_fail | output | 1 | Sticky modulator clock failure flag |

## Verification
On every cycle, the assertions check that a strobe can only follow a detected pin event and that in mode 0 it only follows a rising clock edge. They also check that a rising edge on the skip phase of mode 3 never strobes. For the failure flag, they check that it can only rise after the idle count has reached a nonzero limit, that it holds until cleared, and that it stays low when the limit is zero. The bench scenarios are needed for the rest: the sampled values and their order in each clocked mode, the exact three-cycle latency, the phase restart of mode 3 after a mode change, and Manchester lock and decode over a preamble plus a mixed payload.

// File: rtl/dsin_pkg.sv
package dsin_pkg;

  typedef enum logic [1:0] {
    CAP_RISE   = 2'd0,
    CAP_BOTH   = 2'd1,
    CAP_MANCH  = 2'd2,
    CAP_EVERY2 = 2'd3
  } cap_mode_e;

  // Acceptance window for the next mid-bit transition: 3/4 of the period.
  function automatic int unsigned win_of(int unsigned per);
    return per - (per >> 2);
  endfunction

endpackage

// File: rtl/dsin_sync.sv
module dsin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dsin_edge.sv
module dsin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/dsin_manch.sv
module dsin_manch
  import dsin_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic en,
  input  logic d_rise,
  input  logic d_fall,
  output logic bit_vld,
  output logic bit_val
);
  logic [CNT_W-1:0] per, ivl, since, win;
  logic             seen, tr;

  assign tr      = d_rise | d_fall;
  assign win     = CNT_W'(win_of(32'(per)));
  assign bit_vld = en & tr & (since >= win);
  assign bit_val = d_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per   <= '0;
      ivl   <= '0;
      since <= '1;
      seen  <= 1'b0;
    end else if (restart) begin
      per   <= '0;
      ivl   <= '0;
      since <= '1;
      seen  <= 1'b0;
    end else if (en && tr) begin
      if (seen && ivl > per) per <= ivl;
      ivl   <= CNT_W'(1);
      seen  <= 1'b1;
      since <= bit_vld ? CNT_W'(1) : ((since == '1) ? since : since + 1'b1);
    end else begin
      ivl   <= (ivl == '1) ? ivl : ivl + 1'b1;
      since <= (since == '1) ? since : since + 1'b1;
    end
  end
endmodule

// File: rtl/dsin_clkmon.sv
module dsin_clkmon #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             activity,
  input  logic [TMO_W-1:0] limit,
  input  logic             clr,
  output logic [TMO_W-1:0] idle_cnt,
  output logic             fail
);
  logic expired;

  assign expired = (limit != '0) && (idle_cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      fail     <= 1'b0;
    end else begin
      if (activity || restart)  idle_cnt <= '0;
      else if (idle_cnt != '1)  idle_cnt <= idle_cnt + 1'b1;
      if (expired)              fail <= 1'b1;
      else if (clr)             fail <= 1'b0;
    end
  end
endmodule

// File: rtl/dsin_front.sv
module dsin_front
  import dsin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 12,
  parameter int TMO_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [TMO_W-1:0] timeout,
  input  logic             fail_clr,
  input  logic             mod_clk_pin,
  input  logic             mod_dat_pin,
  output logic             sample_bit,
  output logic             sample_vld,
  output logic             clk_fail
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_raw, pin_s, pin_r, pin_f;
  assign pin_raw = {mod_dat_pin, mod_clk_pin};

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    dsin_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pin_raw[i]), .q(pin_s[i]));
    dsin_edge edge_i (
      .clk(clk), .rst_n(rst_n), .lvl(pin_s[i]), .rise(pin_r[i]), .fall(pin_f[i]));
  end

  // Named internal events, shared with the checker.
  logic clk_rise, clk_fall, dat_s, dat_edge, mode_chg, div_ph;
  logic man_vld, man_bit, take, take_bit, activity;
  logic [1:0] mode_q;
  logic [TMO_W-1:0] idle_cnt;
  cap_mode_e cm;

  assign clk_rise = pin_r[0];
  assign clk_fall = pin_f[0];
  assign dat_s    = pin_s[1];
  assign dat_edge = pin_r[1] | pin_f[1];
  assign mode_chg = (mode != mode_q);
  assign cm       = cap_mode_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      div_ph <= 1'b0;
    end else begin
      mode_q <= mode;
      if (mode_chg || cm != CAP_EVERY2) div_ph <= 1'b0;
      else if (clk_rise)                div_ph <= ~div_ph;
    end
  end

  dsin_manch #(.CNT_W(CNT_W)) manch_i (
    .clk(clk), .rst_n(rst_n), .restart(mode_chg),
    .en(cm == CAP_MANCH && !mode_chg),
    .d_rise(pin_r[1]), .d_fall(pin_f[1]),
    .bit_vld(man_vld), .bit_val(man_bit));

  always_comb begin
    take_bit = dat_s;
    unique case (cm)
      CAP_RISE:   take = clk_rise;
      CAP_BOTH:   take = clk_rise | clk_fall;
      CAP_EVERY2: take = clk_rise & div_ph & ~mode_chg;
      CAP_MANCH: begin
        take     = man_vld;
        take_bit = man_bit;
      end
      default:    take = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_vld <= 1'b0;
      sample_bit <= 1'b0;
    end else begin
      sample_vld <= take;
      if (take) sample_bit <= take_bit;
    end
  end

  assign activity = (cm == CAP_MANCH) ? dat_edge : (clk_rise | clk_fall);

  dsin_clkmon #(.TMO_W(TMO_W)) mon_i (
    .clk(clk), .rst_n(rst_n), .restart(mode_chg), .activity(activity),
    .limit(timeout), .clr(fail_clr), .idle_cnt(idle_cnt), .fail(clk_fail));
endmodule

// File: rtl/dsin_front_chk.sv
module dsin_front_chk #(
  parameter int TMO_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             mode_chg,
  input logic [TMO_W-1:0] timeout,
  input logic             fail_clr,
  input logic             clk_rise,
  input logic             clk_fall,
  input logic             dat_edge,
  input logic             div_ph,
  input logic [TMO_W-1:0] idle_cnt,
  input logic             sample_vld,
  input logic             clk_fail
);
  assert_strobe_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> $past(clk_rise | clk_fall | dat_edge));

  assert_rise_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && mode == 2'd0 && $past(mode) == 2'd0) |-> $past(clk_rise));

  assert_skip_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !mode_chg && clk_rise && !div_ph) |=> !sample_vld);

  assert_fail_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_fail) |-> ($past(timeout) != '0 && $past(idle_cnt) >= $past(timeout)));

  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fail && !fail_clr) |=> clk_fail);

  assert_fail_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout == '0 && !clk_fail) |=> !clk_fail);
endmodule

bind dsin_front dsin_front_chk #(.TMO_W(TMO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .mode_chg(mode_chg),
  .timeout(timeout), .fail_clr(fail_clr), .clk_rise(clk_rise),
  .clk_fall(clk_fall), .dat_edge(dat_edge), .div_ph(div_ph),
  .idle_cnt(idle_cnt), .sample_vld(sample_vld), .clk_fail(clk_fail));

// File: tb/dsin_front_tb.sv
module dsin_front_tb_top;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [TMO_W-1:0] timeout = 16'd1000;
  logic fail_clr = 1'b0;
  logic mclk = 1'b0;
  logic mdat = 1'b0;
  logic sample_bit, sample_vld, clk_fail;

  int checks = 0;
  int errors = 0;
  int ncap = 0;
  logic [31:0] cap = '0;

  always #2.5 clk = ~clk;

  dsin_front dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .timeout(timeout),
    .fail_clr(fail_clr), .mod_clk_pin(mclk), .mod_dat_pin(mdat),
    .sample_bit(sample_bit), .sample_vld(sample_vld), .clk_fail(clk_fail));

  always @(negedge clk) if (rst_n && sample_vld) begin
    cap  = {cap[30:0], sample_bit};
    ncap = ncap + 1;
  end

  // {mode, 8-bit pattern sent MSB first}
  localparam logic [9:0] VEC [6] = '{
    {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd3, 8'h96},
    {2'd0, 8'h0F}, {2'd1, 8'hE1}, {2'd3, 8'h5A}};

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_cap();
    ncap = 0;
    cap  = '0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mclk = 1'b0;
    mdat = 1'b0;
    cyc(8);
    mode = m;
    cyc(8);
    clear_cap();
  endtask

  // One 16-cycle bit slot; the sampling edge lies mid-slot.
  task automatic slot(input logic [1:0] m, input logic b);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      mdat = b;
      case (m)
        2'd0: mclk = (c >= 8);
        2'd1: if (c == 8) mclk = ~mclk;
        2'd3: mclk = c[2];
        default: ;
      endcase
    end
  endtask

  task automatic man_bit(input logic b);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      mdat = (c < 8) ? ~b : b;
    end
  endtask

  task automatic pulse_rise();
    @(negedge clk); mclk = 1'b1;
    cyc(6);
    mclk = 1'b0;
    cyc(6);
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    chk(sample_vld == 1'b0 && clk_fail == 1'b0, "R1 in reset", {sample_vld, clk_fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample_vld == 1'b0 && clk_fail == 1'b0, "R1 after reset", {sample_vld, clk_fail}, 0);

    // Table walk over the clocked modes (R2, R3, R4).
    foreach (VEC[v]) begin
      set_mode(VEC[v][9:8]);
      for (int k = 7; k >= 0; k--) slot(VEC[v][9:8], VEC[v][k]);
      cyc(8);
      chk(ncap == 8, $sformatf("R2/R3/R4 count mode %0d (R%0d)", VEC[v][9:8],
          VEC[v][9:8] == 2'd0 ? 2 : (VEC[v][9:8] == 2'd1 ? 3 : 4)), ncap, 8);
      chk(cap[7:0] == VEC[v][7:0], $sformatf("R2/R3/R4 bits mode %0d", VEC[v][9:8]),
          cap[7:0], VEC[v][7:0]);
    end

    // R2: latency and one-cycle width.
    set_mode(2'd0);
    @(negedge clk); mclk = 1'b1; mdat = 1'b1;
    cyc(2);
    chk(sample_vld == 1'b0, "R2 latency early", sample_vld, 0);
    cyc(1);
    chk(sample_vld == 1'b1 && sample_bit == 1'b1, "R2 latency strobe", {sample_vld, sample_bit}, 3);
    cyc(1);
    chk(sample_vld == 1'b0, "R2 strobe width", sample_vld, 0);
    mclk = 1'b0;
    cyc(8);

    // R4: phase restarts after a mode change.
    set_mode(2'd3);
    pulse_rise();
    set_mode(2'd0);
    set_mode(2'd3);
    pulse_rise();
    chk(ncap == 0, "R4 first rise after mode change skipped", ncap, 0);
    pulse_rise();
    chk(ncap == 1, "R4 second rise sampled", ncap, 1);

    // R5: Manchester preamble 1010 then payload 11001000.
    set_mode(2'd2);
    begin
      logic [11:0] seq;
      seq = 12'b1010_1100_1000;
      for (int k = 11; k >= 0; k--) man_bit(seq[k]);
      cyc(8);
      chk(ncap == 12, "R5 decoded count", ncap, 12);
      chk(cap[11:0] == seq, "R5 decoded bits", cap[11:0], seq);
    end

    // R6 / R7 / R8: clock loss monitor.
    timeout = 16'd40;
    set_mode(2'd0);
    for (int k = 0; k < 6; k++) slot(2'd0, 1'b0);
    chk(clk_fail == 1'b0, "R6 running clock no fail", clk_fail, 0);
    cyc(25);
    chk(clk_fail == 1'b0, "R6 short gap no fail", clk_fail, 0);
    cyc(40);
    chk(clk_fail == 1'b1, "R6 long gap fail", clk_fail, 1);
    fail_clr = 1'b1; cyc(1); fail_clr = 1'b0; cyc(2);
    chk(clk_fail == 1'b1, "R7 clear while idle keeps flag", clk_fail, 1);
    slot(2'd0, 1'b0);
    chk(clk_fail == 1'b1, "R7 sticky after clock returns", clk_fail, 1);
    fail_clr = 1'b1;
    slot(2'd0, 1'b0);
    fail_clr = 1'b0;
    for (int k = 0; k < 3; k++) slot(2'd0, 1'b0);
    chk(clk_fail == 1'b0, "R7 cleared with clock running", clk_fail, 0);

    // R6 in mode 2: data transitions are the activity.
    set_mode(2'd2);
    for (int k = 0; k < 6; k++) man_bit(k[0]);
    chk(clk_fail == 1'b0, "R6 manchester activity no fail", clk_fail, 0);
    cyc(80);
    chk(clk_fail == 1'b1, "R6 manchester idle fail", clk_fail, 1);

    // R8: zero limit disables detection.
    timeout = '0;
    set_mode(2'd0);
    fail_clr = 1'b1; cyc(2); fail_clr = 1'b0;
    cyc(200);
    chk(clk_fail == 1'b0, "R8 zero timeout no fail", clk_fail, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule